// File: doc/BRIEF.md
# Cache Line Range Maintenance Sequencer

This block walks a contiguous range of cache lines and issues one maintenance command for each line on a downstream line-command port. A range request takes two command writes. The first write gives the start address. The second write gives the inclusive end address and selects the operation, clean or invalidate. The second write launches the walk. Each line whose base address lies in [start, end] gets one command, in ascending order and 32 bytes apart. The requester sees a stall output that stays high until the walk is over.

The same command port also accepts three single-line operations (clean, invalidate, clean-and-invalidate) and one command that invalidates the whole cache. Each of these sends exactly one downstream command. The range must stay inside one 4096-byte page. A request whose start and end lie in different pages raises an error flag and touches no line. A range that contains no line base, including one whose end is below its start, also touches no line. In both cases the stall lasts a single cycle.

Top module: `lineRangeSeq`

## Requirements
- R1: After a start write followed by a range-end write, one downstream command is issued for every line base B (a multiple of 32) with start <= B <= end. The commands come in ascending order, each address 32 above the previous one, and every address has bits [4:0] equal to zero.
- R2: cmdKind encoding: 0 = set start, 1 = range end and clean, 2 = range end and invalidate, 3 = single-line clean, 4 = single-line invalidate, 5 = single-line clean-and-invalidate, 6 = invalidate entire cache, 7 = ignored. lineOp encoding: 0 = clean, 1 = invalidate, 2 = clean-and-invalidate, 3 = invalidate all. A range clean issues lineOp 0 and a range invalidate issues lineOp 1.
- R3: stall rises in the cycle after a launching command is accepted. It stays high until the cycle after the final downstream handshake, and then falls. A command is accepted only when cmdValid is high and stall is low. A command presented while stall is high is dropped.
- R4: While lineValid is high and lineReady is low, lineValid stays high and lineAddr and lineOp hold their values. The walker advances only on a cycle in which lineReady is high.
- R5: A range launch whose start and end differ in address bits [31:12] sets errFlag to 1, issues no downstream command, and holds stall high for exactly one cycle.
- R6: A range launch with matching page bits but no line base in [start, end] leaves errFlag at 0, issues no command, and holds stall high for exactly one cycle. This covers an end below the start, and a start above the last line base of its page.
- R7: A range-end write with no pending start is ignored: no stall, no command, and errFlag is unchanged. Any accepted command other than set start (kinds 1 to 6) cancels a pending start. A later range-end write is then ignored.
- R8: A single-line command issues exactly one downstream command. Its address is cmdAddr with bits [4:0] cleared, and its lineOp is 0, 1 or 2 for kinds 3, 4 or 5.
- R9: The invalidate-entire-cache command issues exactly one downstream command with lineOp 3 and address 0.
- R10: After reset, stall, lineValid and errFlag are 0 and no start is pending.
- R11: errFlag takes a new value at every accepted launching command: a range launch with a page mismatch sets it, and every other launch clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command write strobe |
| cmdKind | input | 3 | Command kind (see R2) |
| cmdAddr | input | 32 | Command address |
| stall | output | 1 | Requester stall |
| errFlag | output | 1 | Last range launch crossed a page |
| lineValid | output | 1 | Downstream line command valid |
| lineReady | input | 1 | Downstream ready |
| lineAddr | output | 32 | Line base address |
| lineOp | output | 2 | Line operation (see R2) |

## Verification
Every output is registered. A command accepted at one rising edge first shows on stall, errFlag and lineValid after that edge. A handshake at one edge moves lineAddr, or drops stall, after that same edge. The bench drives cmdValid, cmdKind, cmdAddr and lineReady on falling edges. A behavioural model takes the same inputs at each rising edge, and the bench compares its outputs with the design's at the next falling edge, every cycle. Each scenario then waits for idle and compares the handshake count, which it counts from the ports, with a count worked out from the range arithmetic of the requirements.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

  typedef enum logic [2:0] {
    CMD_START       = 3'd0,
    CMD_END_CLEAN   = 3'd1,
    CMD_END_INV     = 3'd2,
    CMD_LINE_CLEAN  = 3'd3,
    CMD_LINE_INV    = 3'd4,
    CMD_LINE_CLNINV = 3'd5,
    CMD_INV_ALL     = 3'd6,
    CMD_NONE        = 3'd7
  } cmdKindE;

  typedef enum logic [1:0] {
    OP_CLEAN  = 2'd0,
    OP_INV    = 2'd1,
    OP_CLNINV = 2'd2,
    OP_INVALL = 2'd3
  } lineOpE;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_FLUSH = 2'd2
  } seqStateE;

  // control-to-datapath strobes
  typedef struct packed {
    logic   ldStart;
    logic   ldRange;
    logic   ldSingle;
    logic   ldAll;
    logic   step;
    lineOpE opSel;
  } seqStrobeS;

endpackage

// File: rtl/lrsDatapath.sv
module lrsDatapath
  import lrs_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobeS         strobe,
  input  logic [ADDR_W-1:0] cmdAddr,
  output logic              pageBad,
  output logic              rangeEmpty,
  output logic              atLast,
  output logic [ADDR_W-1:0] lineAddr,
  output lineOpE            lineOp,
  output logic              errFlag
);

  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int PG_W  = $clog2(PAGE_BYTES);

  logic [ADDR_W-1:0] startReg;
  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] lastAddr;
  lineOpE            opReg;
  logic              errReg;

  logic [PG_W:0]       sumOff;
  logic [PG_W:0]       firstOff;
  logic [PG_W:0]       lastOff;
  logic [ADDR_W-1:0]   cmdBase;
  logic [ADDR_W-1:0]   firstAddr;

  // first line base at or above start, kept as a page offset with a carry bit
  always_comb begin
    sumOff    = {1'b0, startReg[PG_W-1:0]} + (PG_W+1)'(LINE_BYTES - 1);
    firstOff  = {sumOff[PG_W:OFF_W], {OFF_W{1'b0}}};
    lastOff   = {1'b0, cmdAddr[PG_W-1:OFF_W], {OFF_W{1'b0}}};
    cmdBase   = {cmdAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    firstAddr = {startReg[ADDR_W-1:PG_W], firstOff[PG_W-1:0]};
  end

  assign pageBad    = startReg[ADDR_W-1:PG_W] != cmdAddr[ADDR_W-1:PG_W];
  assign rangeEmpty = firstOff > lastOff;
  assign atLast     = curAddr == lastAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startReg <= '0;
      curAddr  <= '0;
      lastAddr <= '0;
      opReg    <= OP_CLEAN;
      errReg   <= 1'b0;
    end else begin
      if (strobe.ldStart) begin
        startReg <= cmdAddr;
      end
      if (strobe.ldRange) begin
        curAddr  <= firstAddr;
        lastAddr <= cmdBase;
        opReg    <= strobe.opSel;
        errReg   <= pageBad;
      end else if (strobe.ldSingle) begin
        curAddr  <= cmdBase;
        lastAddr <= cmdBase;
        opReg    <= strobe.opSel;
        errReg   <= 1'b0;
      end else if (strobe.ldAll) begin
        curAddr  <= '0;
        lastAddr <= '0;
        opReg    <= OP_INVALL;
        errReg   <= 1'b0;
      end else if (strobe.step) begin
        curAddr  <= curAddr + ADDR_W'(LINE_BYTES);
      end
    end
  end

  assign lineAddr = curAddr;
  assign lineOp   = opReg;
  assign errFlag  = errReg;

  // walking never leaves the page of the range
  AST_STEP_IN_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> curAddr[ADDR_W-1:PG_W] == $past(curAddr[ADDR_W-1:PG_W])); // R1

  // a step is only taken before the last line is reached
  AST_STEP_NOT_LAST: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> curAddr < lastAddr); // R1

endmodule

// File: rtl/lrsControl.sv
module lrsControl
  import lrs_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdValid,
  input  logic [2:0] cmdKind,
  input  logic      lineReady,
  input  logic      pageBad,
  input  logic      rangeEmpty,
  input  logic      atLast,
  output seqStrobeS strobe,
  output logic      stall,
  output logic      lineValid
);

  seqStateE stateQ, stateD;
  logic     pendQ, pendD;
  cmdKindE  kind;

  assign kind = cmdKindE'(cmdKind);

  always_comb begin
    strobe = '0;
    stateD = stateQ;
    pendD  = pendQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (cmdValid) begin
          unique case (kind)
            CMD_START: begin
              strobe.ldStart = 1'b1;
              pendD          = 1'b1;
            end
            CMD_END_CLEAN, CMD_END_INV: begin
              if (pendQ) begin
                pendD          = 1'b0;
                strobe.ldRange = 1'b1;
                strobe.opSel   = (kind == CMD_END_CLEAN) ? OP_CLEAN : OP_INV;
                stateD         = (pageBad || rangeEmpty) ? ST_FLUSH : ST_ISSUE;
              end
            end
            CMD_LINE_CLEAN, CMD_LINE_INV, CMD_LINE_CLNINV: begin
              pendD           = 1'b0;
              strobe.ldSingle = 1'b1;
              strobe.opSel    = (kind == CMD_LINE_CLEAN) ? OP_CLEAN :
                                (kind == CMD_LINE_INV)   ? OP_INV : OP_CLNINV;
              stateD          = ST_ISSUE;
            end
            CMD_INV_ALL: begin
              pendD        = 1'b0;
              strobe.ldAll = 1'b1;
              stateD       = ST_ISSUE;
            end
            default: begin
            end
          endcase
        end
      end
      ST_ISSUE: begin
        if (lineReady) begin
          if (atLast) begin
            stateD = ST_IDLE;
          end else begin
            strobe.step = 1'b1;
          end
        end
      end
      ST_FLUSH: begin
        stateD = ST_IDLE;
      end
      default: begin
        stateD = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      pendQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      pendQ  <= pendD;
    end
  end

  assign stall     = stateQ != ST_IDLE;
  assign lineValid = stateQ == ST_ISSUE;

  // an unanswered command stays offered
  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rstN)
    lineValid && !lineReady |=> lineValid); // R4

  // a stall without any line command lasts one cycle
  AST_FLUSH_ONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stall) && !lineValid |=> !stall); // R6

  // nothing is loaded while the requester is held
  AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> !(strobe.ldStart || strobe.ldRange || strobe.ldSingle || strobe.ldAll)); // R3

endmodule

// File: rtl/lineRangeSeq.sv
module lineRangeSeq
  import lrs_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdKind,
  input  logic [ADDR_W-1:0] cmdAddr,
  output logic              stall,
  output logic              errFlag,
  output logic              lineValid,
  input  logic              lineReady,
  output logic [ADDR_W-1:0] lineAddr,
  output logic [1:0]        lineOp
);

  localparam int OFF_W = $clog2(LINE_BYTES);

  seqStrobeS strobe;
  logic      pageBad;
  logic      rangeEmpty;
  logic      atLast;
  lineOpE    opOut;

  lrsControl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .cmdKind    (cmdKind),
    .lineReady  (lineReady),
    .pageBad    (pageBad),
    .rangeEmpty (rangeEmpty),
    .atLast     (atLast),
    .strobe     (strobe),
    .stall      (stall),
    .lineValid  (lineValid)
  );

  lrsDatapath #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES),
    .PAGE_BYTES (PAGE_BYTES)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cmdAddr    (cmdAddr),
    .pageBad    (pageBad),
    .rangeEmpty (rangeEmpty),
    .atLast     (atLast),
    .lineAddr   (lineAddr),
    .lineOp     (opOut),
    .errFlag    (errFlag)
  );

  assign lineOp = opOut;

  AST_VALID_STALL: assert property (@(posedge clk) disable iff (!rstN)
    lineValid |-> stall); // R3

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    lineValid && !lineReady |=> $stable(lineAddr) && $stable(lineOp)); // R4

  AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    lineValid |-> lineAddr[OFF_W-1:0] == '0); // R1

  AST_NEXT_LINE: assert property (@(posedge clk) disable iff (!rstN)
    lineValid && lineReady |=> !lineValid || lineAddr == $past(lineAddr) + ADDR_W'(LINE_BYTES)); // R1

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> !lineValid); // R5

endmodule

// File: tb/lineRangeSeq_test.sv
module lineRangeSeq_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdKind = 3'd7;
  logic [31:0] cmdAddr = '0;
  logic        lineReady = 1'b0;
  logic        stall, errFlag, lineValid;
  logic [31:0] lineAddr;
  logic [1:0]  lineOp;

  always #2 clk = ~clk; // 250 MHz

  lineRangeSeq uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdKind(cmdKind),
    .cmdAddr(cmdAddr), .stall(stall), .errFlag(errFlag),
    .lineValid(lineValid), .lineReady(lineReady),
    .lineAddr(lineAddr), .lineOp(lineOp)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;
  int hsCount = 0;
  int readyMode = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit finished = 0;

  // behavioural reference model
  logic [31:0] qa[$];
  int          qo[$];
  bit          mFlush = 0;
  bit          mErr = 0;
  bit          mPend = 0;
  logic [31:0] mStart = '0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  function automatic int expLines(logic [31:0] s, logic [31:0] e);
    longint b;
    int n = 0;
    if (s[31:12] != e[31:12]) return 0;
    b = ((longint'(s) + 31) / 32) * 32;
    while (b <= longint'(e)) begin
      n++;
      b += 32;
    end
    return n;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      qa.delete(); qo.delete();
      mFlush = 0; mErr = 0; mPend = 0; mStart = '0;
    end else if (qa.size() > 0) begin
      if (lineReady) begin
        void'(qa.pop_front());
        void'(qo.pop_front());
      end
    end else if (mFlush) begin
      mFlush = 0;
    end else if (cmdValid) begin
      case (cmdKind)
        3'd0: begin mStart = cmdAddr; mPend = 1; end
        3'd1, 3'd2: if (mPend) begin
          mPend = 0;
          if (mStart[31:12] != cmdAddr[31:12]) begin
            mErr = 1; mFlush = 1;
          end else begin
            longint b;
            mErr = 0;
            b = ((longint'(mStart) + 31) / 32) * 32;
            while (b <= longint'(cmdAddr)) begin
              qa.push_back(32'(b));
              qo.push_back(cmdKind == 3'd1 ? 0 : 1);
              b += 32;
            end
            if (qa.size() == 0) mFlush = 1;
          end
        end
        3'd3, 3'd4, 3'd5: begin
          mPend = 0; mErr = 0;
          qa.push_back({cmdAddr[31:5], 5'b0});
          qo.push_back(int'(cmdKind) - 3);
        end
        3'd6: begin
          mPend = 0; mErr = 0;
          qa.push_back('0);
          qo.push_back(3);
        end
        default: begin end
      endcase
    end
  end

  // compare on every clock, then drive ready and count handshakes
  always @(negedge clk) begin
    if (rstN && !finished) begin
      bit eValid;
      bit eStall;
      eValid = qa.size() > 0;
      eStall = eValid || mFlush;
      chk(stall == eStall, "R3 stall", 32'(stall), 32'(eStall));
      chk(lineValid == eValid, "R1 lineValid", 32'(lineValid), 32'(eValid));
      chk(errFlag == mErr, "R5 errFlag", 32'(errFlag), 32'(mErr));
      if (eValid) begin
        chk(lineAddr == qa[0], "R1 lineAddr", lineAddr, qa[0]);
        chk(int'(lineOp) == qo[0], "R2 lineOp", 32'(lineOp), 32'(qo[0]));
      end
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (readyMode)
      0: lineReady = 1'b1;
      1: lineReady = lfsr[0];
      default: lineReady = lfsr[0] & lfsr[3];
    endcase
    if (lineValid && lineReady) hsCount++;
  end

  task automatic pulse(logic [2:0] k, logic [31:0] a);
    @(negedge clk);
    cmdValid = 1'b1; cmdKind = k; cmdAddr = a;
    @(negedge clk);
    cmdValid = 1'b0; cmdKind = 3'd7;
  endtask

  task automatic waitIdle();
    int quiet = 0;
    while (quiet < 3) begin
      @(negedge clk);
      #1;
      if (!stall && qa.size() == 0 && !mFlush) quiet++;
      else quiet = 0;
    end
  endtask

  task automatic rangeRun(logic [2:0] k, logic [31:0] s, logic [31:0] e, string tag);
    hsCount = 0;
    pulse(3'd0, s);
    pulse(k, e);
    waitIdle();
    chk(hsCount == expLines(s, e), tag, 32'(hsCount), 32'(expLines(s, e)));
  endtask

  task automatic summary();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000 && !finished) begin
      total++; bad++;
      $display("FAIL watchdog expired act=%0d exp=done", cycles);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk(stall == 0, "R10 reset stall", 32'(stall), 0);
    chk(lineValid == 0, "R10 reset lineValid", 32'(lineValid), 0);
    chk(errFlag == 0, "R10 reset errFlag", 32'(errFlag), 0);
    // no pending start after reset: an end write alone is ignored
    hsCount = 0;
    pulse(3'd1, 32'h0000_0040);
    @(negedge clk); #1;
    chk(stall == 0, "R10 R7 no pending start", 32'(stall), 0);

    readyMode = 0;
    rangeRun(3'd1, 32'h0000_1000, 32'h0000_1040, "R1 aligned clean range");
    readyMode = 1;
    rangeRun(3'd2, 32'h0000_2005, 32'h0000_20A0, "R1 unaligned invalidate range");
    rangeRun(3'd1, 32'h0000_3FE0, 32'h0000_4000, "R5 page crossing");
    #1 chk(errFlag == 1, "R5 errFlag set", 32'(errFlag), 1);
    rangeRun(3'd2, 32'h0000_5100, 32'h0000_5000, "R6 end below start");
    #1 chk(errFlag == 0, "R11 errFlag cleared", 32'(errFlag), 0);
    rangeRun(3'd1, 32'h0000_6FE1, 32'h0000_6FFF, "R6 start past last line");
    rangeRun(3'd2, 32'h0000_6F01, 32'h0000_6F1F, "R6 no base inside range");

    // R7: another command cancels a pending start
    hsCount = 0;
    pulse(3'd0, 32'h0000_7000);
    pulse(3'd3, 32'h0000_7013);
    waitIdle();
    pulse(3'd2, 32'h0000_7100);
    waitIdle();
    chk(hsCount == 1, "R7 cancelled start", 32'(hsCount), 1);

    // error is kept by an ignored end write, cleared by a single-line op
    rangeRun(3'd1, 32'h0000_AFE0, 32'h0000_B020, "R5 second page crossing");
    pulse(3'd2, 32'h0000_B040);
    waitIdle(); #1;
    chk(errFlag == 1, "R7 ignored end keeps errFlag", 32'(errFlag), 1);
    hsCount = 0;
    pulse(3'd4, 32'h0000_C0FF);
    waitIdle(); #1;
    chk(errFlag == 0, "R11 single op clears errFlag", 32'(errFlag), 0);
    chk(hsCount == 1, "R8 single invalidate", 32'(hsCount), 1);

    hsCount = 0;
    pulse(3'd5, 32'h1234_5678);
    waitIdle();
    chk(hsCount == 1, "R8 single clean-and-invalidate", 32'(hsCount), 1);

    hsCount = 0;
    pulse(3'd6, 32'hFFFF_FFFF);
    waitIdle();
    chk(hsCount == 1, "R9 invalidate all", 32'(hsCount), 1);

    hsCount = 0;
    pulse(3'd7, 32'h0000_0100);
    waitIdle();
    chk(hsCount == 0, "R2 kind 7 ignored", 32'(hsCount), 0);

    // R3: a command during the stall is dropped
    readyMode = 2;
    hsCount = 0;
    pulse(3'd0, 32'h0000_8000);
    pulse(3'd2, 32'h0000_8FE0);
    pulse(3'd3, 32'h0000_1234);
    pulse(3'd6, 32'h0);
    waitIdle();
    chk(hsCount == 128, "R3 full page walk, commands dropped", 32'(hsCount), 128);

    readyMode = 1;
    rangeRun(3'd1, 32'h0000_9FE0, 32'h0000_9FFF, "R1 last line of page");
    rangeRun(3'd2, 32'h0000_D000, 32'h0000_D000, "R1 single line range");
    rangeRun(3'd1, 32'h0000_E000, 32'h0000_E01F, "R1 within one line");

    summary();
  end

endmodule